// File: doc/BRIEF.md
# Grouped Multi-Channel Conversion Sequencer

This block sequences a bank of one to seven converter channels that all run from one shared modulator clock. Each channel has a busy (start) bit, a one-shot select and a link select. Link selects chain neighbouring channels into groups. The highest channel of each chain is the group's master. A start request on the master starts every member in the same cycle, so the whole group converts in lockstep. A stop request on the master aborts the whole group.

Each conversion is modelled as a fixed number of modulator ticks. When the last tick arrives, the channel latches its sample, raises a valid flag and pulses a done strobe for one clock. A one-shot channel then drops its busy bit. A continuous channel restarts its count at once. The block raises the modulator clock enable only while at least one channel is busy.

Top module: `grpconv_seq`

## Requirements
- R1: `master_o[c]` is 1 exactly when the effective link bit of channel c is 0. The link input of the highest channel is forced to 0, so that channel is always a master. Channel c belongs to the group of the lowest channel m >= c whose effective link bit is 0.
- R2: `mod_clk_en_o` is 1 exactly when at least one bit of `start_o` is 1.
- R3: A `start_set_i` pulse on a master sets `start_o` for every member of its group on the next clock edge. All members restart their tick count from zero at that edge, so they complete on the same cycle.
- R4: A `start_set_i` pulse on a channel that is not a master has no effect.
- R5: While busy, a channel counts `tick_i` pulses. On the OSR-th tick it latches its `sample_i` slice into `result_o`, sets its `valid_o` bit and drives its `done_o` bit high for exactly one cycle.
- R6: In one-shot mode (`single_i[c]`=1), the channel's `start_o` bit clears at the edge where its conversion completes.
- R7: In continuous mode (`single_i[c]`=0), the `start_o` bit stays set across a completion and the next conversion starts counting at once.
- R8: A `start_clr_i` pulse on a channel that is not a master clears only that channel's `start_o` bit.
- R9: A `start_clr_i` pulse on a master clears `start_o` for every member of its group on the next edge, discards their partial counts and produces no `done_o`.
- R10: The `valid_o` bit of a channel clears when its busy bit is cleared by request or when it is started again. A conversion that is cut short never sets it.
- R11: When requests collide in one cycle, a clear beats a start, and a start beats a completion.
- R12: `tick_i` has no effect on a channel whose `start_o` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per modulator clock period |
| link_i | input | NCH | Per-channel link select (joins channel c to c+1) |
| single_i | input | NCH | Per-channel one-shot select |
| start_set_i | input | NCH | Per-channel start request pulses |
| start_clr_i | input | NCH | Per-channel stop request pulses |
| sample_i | input | NCH*RES_W | Per-channel filter output, captured at completion |
| start_o | output | NCH | Per-channel busy bits |
| master_o | output | NCH | Marks channels that are group masters |
| mod_clk_en_o | output | 1 | Enable for the shared modulator clock |
| done_o | output | NCH | One-cycle completion strobes |
| valid_o | output | NCH | Result-valid flags |
| result_o | output | NCH*RES_W | Latched per-channel results |

## Verification
A directed part builds one linked group of three channels and a lone channel. It shows a start on a member being ignored and a start on the master reaching all members together. It then compares a one-shot finish with a continuous restart. A member stop is checked against a master abort taken mid-count, and a colliding set and clear is checked against the priority rule. A random part then changes the link and one-shot patterns every few dozen cycles and sends sparse start and stop pulses with irregular ticks. This exposes chains of every length, masters changing under running channels, and collisions between requests and completions, none of which the directed cases reach.

// File: rtl/grpconv_pkg.sv
package grpconv_pkg;

    // Channel mode, encoded {one-shot, link}
    typedef enum logic [1:0] {
        MODE_SOLO_CONT = 2'b00,
        MODE_GRP_CONT  = 2'b01,
        MODE_SOLO_ONCE = 2'b10,
        MODE_GRP_ONCE  = 2'b11
    } conv_mode_e;

    function automatic logic stops_after_one(conv_mode_e m);
        return (m == MODE_SOLO_ONCE) || (m == MODE_GRP_ONCE);
    endfunction

endpackage

// File: rtl/grpconv_map.sv
module grpconv_map #(
    parameter int NCH = 7
) (
    input  logic [NCH-1:0] link_i,
    input  logic [NCH-1:0] set_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] link_eff_o,
    output logic [NCH-1:0] master_o,
    output logic [NCH-1:0] grp_set_o,
    output logic [NCH-1:0] grp_clr_o
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [NCH-1:0] TOP_MASK = ~(NCH'(1) << (NCH - 1));

    logic [NCH-1:0] leff;
    logic [IDX_W-1:0] owner [NCH];

    assign leff       = link_i & TOP_MASK;
    assign link_eff_o = leff;
    assign master_o   = ~leff;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            logic found;
            found    = 1'b0;
            owner[c] = IDX_W'(NCH - 1);
            for (int j = 0; j < NCH; j++) begin
                if (j >= c && !found && !leff[j]) begin
                    owner[c] = IDX_W'(j);
                    found    = 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            grp_set_o[c] = set_i[owner[c]];
            grp_clr_o[c] = clr_i[c] | clr_i[owner[c]];
        end
    end

endmodule

// File: rtl/grpconv_chan.sv
module grpconv_chan
    import grpconv_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             grp_set_i,
    input  logic             grp_clr_i,
    input  logic             single_i,
    input  logic             link_i,
    input  logic [RES_W-1:0] sample_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             valid_o,
    output logic [RES_W-1:0] result_o
);
    localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             valid;
        logic [RES_W-1:0] res;
    } chan_st_t;

    chan_st_t st_d, st_q;
    conv_mode_e mode;

    assign mode = conv_mode_e'({single_i, link_i});

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (grp_clr_i) begin
            st_d.busy  = 1'b0;
            st_d.cnt   = '0;
            st_d.valid = 1'b0;
        end else if (grp_set_i) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.valid = 1'b0;
        end else if (st_q.busy && tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.done  = 1'b1;
                st_d.valid = 1'b1;
                st_d.res   = sample_i;
                st_d.cnt   = '0;
                st_d.busy  = !stops_after_one(mode);
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign valid_o  = st_q.valid;
    assign result_o = st_q.res;

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && $past(single_i) |-> !busy_o);

    // R9
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_clr_i |=> !busy_o && !valid_o && !done_o);

    // R12
    idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !done_o);

    // R5
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);

endmodule

// File: rtl/grpconv_seq.sv
module grpconv_seq #(
    parameter int NCH   = 7,
    parameter int OSR   = 16,
    parameter int RES_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [NCH-1:0]       link_i,
    input  logic [NCH-1:0]       single_i,
    input  logic [NCH-1:0]       start_set_i,
    input  logic [NCH-1:0]       start_clr_i,
    input  logic [NCH*RES_W-1:0] sample_i,
    output logic [NCH-1:0]       start_o,
    output logic [NCH-1:0]       master_o,
    output logic                 mod_clk_en_o,
    output logic [NCH-1:0]       done_o,
    output logic [NCH-1:0]       valid_o,
    output logic [NCH*RES_W-1:0] result_o
);
    logic [NCH-1:0] link_eff;
    logic [NCH-1:0] grp_set;
    logic [NCH-1:0] grp_clr;

    grpconv_map #(.NCH(NCH)) u_map (
        .link_i     (link_i),
        .set_i      (start_set_i),
        .clr_i      (start_clr_i),
        .link_eff_o (link_eff),
        .master_o   (master_o),
        .grp_set_o  (grp_set),
        .grp_clr_o  (grp_clr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        grpconv_chan #(.OSR(OSR), .RES_W(RES_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_i),
            .grp_set_i (grp_set[c]),
            .grp_clr_i (grp_clr[c]),
            .single_i  (single_i[c]),
            .link_i    (link_eff[c]),
            .sample_i  (sample_i[c*RES_W +: RES_W]),
            .busy_o    (start_o[c]),
            .done_o    (done_o[c]),
            .valid_o   (valid_o[c]),
            .result_o  (result_o[c*RES_W +: RES_W])
        );

        // R3
        grp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_set[c] && !grp_clr[c] |=> start_o[c]);

        // R4
        only_grp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !start_o[c] && !grp_set[c] |=> !start_o[c]);
    end

    // Shared modulator clock runs only while some channel converts
    assign mod_clk_en_o = |start_o;

    // R2
    clk_en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_clk_en_o) |-> $past(|start_set_i));

endmodule

// File: tb/grpconv_seq_tb.sv
module grpconv_seq_tb;
    localparam int NCH   = 7;
    localparam int OSR   = 4;
    localparam int RES_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 tick_i = 1'b0;
    logic [NCH-1:0]       link_i = '0;
    logic [NCH-1:0]       single_i = '0;
    logic [NCH-1:0]       start_set_i = '0;
    logic [NCH-1:0]       start_clr_i = '0;
    logic [NCH*RES_W-1:0] sample_i = '0;
    logic [NCH-1:0]       start_o, master_o, done_o, valid_o;
    logic                 mod_clk_en_o;
    logic [NCH*RES_W-1:0] result_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    grpconv_seq #(.NCH(NCH), .OSR(OSR), .RES_W(RES_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .link_i(link_i),
        .single_i(single_i), .start_set_i(start_set_i), .start_clr_i(start_clr_i),
        .sample_i(sample_i), .start_o(start_o), .master_o(master_o),
        .mod_clk_en_o(mod_clk_en_o), .done_o(done_o), .valid_o(valid_o),
        .result_o(result_o)
    );

    // Behavioural reference model
    int m_busy [NCH];
    int m_cnt  [NCH];
    int m_done [NCH];
    int m_valid[NCH];
    int m_res  [NCH];

    function automatic int owner_of(int c);
        for (int j = c; j < NCH; j++)
            if (j == NCH - 1 || !link_i[j]) return j;
        return NCH - 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_busy[c] = 0; m_cnt[c] = 0; m_done[c] = 0; m_valid[c] = 0; m_res[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                int own;
                own = owner_of(c);
                m_done[c] = 0;
                if (start_clr_i[c] || start_clr_i[own]) begin
                    m_busy[c] = 0; m_cnt[c] = 0; m_valid[c] = 0;
                end else if (start_set_i[own]) begin
                    m_busy[c] = 1; m_cnt[c] = 0; m_valid[c] = 0;
                end else if (m_busy[c] != 0 && tick_i) begin
                    m_cnt[c] = m_cnt[c] + 1;
                    if (m_cnt[c] == OSR) begin
                        m_cnt[c] = 0; m_done[c] = 1; m_valid[c] = 1;
                        m_res[c] = int'(sample_i[c*RES_W +: RES_W]);
                        if (single_i[c]) m_busy[c] = 0;
                    end
                end
            end
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [NCH-1:0] e_busy, e_done, e_valid, e_master;
            e_busy = '0; e_done = '0; e_valid = '0; e_master = '0;
            for (int c = 0; c < NCH; c++) begin
                e_busy[c]   = (m_busy[c] != 0);
                e_done[c]   = (m_done[c] != 0);
                e_valid[c]  = (m_valid[c] != 0);
                e_master[c] = (owner_of(c) == c);
            end
            check("R1 master", 64'(master_o), 64'(e_master));
            check("R3 start", 64'(start_o), 64'(e_busy));
            check("R2 clk_en", 64'(mod_clk_en_o), 64'(|e_busy));
            check("R5 done", 64'(done_o), 64'(e_done));
            check("R10 valid", 64'(valid_o), 64'(e_valid));
            for (int c = 0; c < NCH; c++)
                check("R5 result", 64'(result_o[c*RES_W +: RES_W]), 64'(m_res[c] & 16'hFFFF));
        end
    end

    // Fresh samples every cycle
    always @(negedge clk) begin
        #1;
        for (int c = 0; c < NCH; c++)
            sample_i[c*RES_W +: RES_W] = RES_W'($urandom);
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic pulse(logic [NCH-1:0] s, logic [NCH-1:0] k);
        start_set_i = s; start_clr_i = k;
        step();
        start_set_i = '0; start_clr_i = '0;
    endtask

    task automatic wait_done(int ch);
        for (int i = 0; i < 40; i++) begin
            step();
            if (done_o[ch]) break;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        check("R2 reset clk_en", 64'(mod_clk_en_o), 64'd0);
        check("R3 reset start", 64'(start_o), 64'd0);

        tick_i = 1'b1;
        link_i = 7'b1000011;           // group {0,1,2}, top link ignored
        single_i = 7'b0000111;
        step();
        check("R1 master map", 64'(master_o), 64'h7C);

        pulse(7'b0000001, '0);
        check("R4 member start ignored", 64'(start_o), 64'd0);

        pulse(7'b0000100, '0);
        check("R3 group start", 64'(start_o), 64'h07);
        check("R2 clk_en on", 64'(mod_clk_en_o), 64'd1);

        wait_done(2);
        check("R3 lockstep done", 64'(done_o), 64'h07);
        check("R6 one-shot stop", 64'(start_o), 64'd0);
        check("R5 valid set", 64'(valid_o), 64'h07);
        step();
        check("R5 done one cycle", 64'(done_o), 64'd0);
        check("R2 clk_en off", 64'(mod_clk_en_o), 64'd0);

        single_i[3] = 1'b0;
        pulse(7'b0001000, '0);
        wait_done(3);
        check("R7 continuous stays", 64'(start_o[3]), 64'd1);
        wait_done(3);
        check("R7 second done", 64'(done_o[3]), 64'd1);

        pulse(7'b0001000, 7'b0001000);
        check("R11 clear beats set", 64'(start_o[3]), 64'd0);

        single_i[2:0] = 3'b000;
        pulse(7'b0000100, '0);
        step();
        pulse('0, 7'b0000010);
        check("R8 member stop", 64'(start_o[2:0]), 64'h5);
        pulse('0, 7'b0000100);
        check("R9 master abort", 64'(start_o[2:0]), 64'h0);
        check("R10 abort not valid", 64'(valid_o[2:0]), 64'h0);
        for (int i = 0; i < 6; i++) step();
        check("R12 idle ticks", 64'(done_o), 64'd0);
        check("R10 still invalid", 64'(valid_o[2:0]), 64'h0);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            if (n % 40 == 0) begin
                link_i   = NCH'($urandom);
                single_i = NCH'($urandom);
            end
            tick_i = ($urandom % 2) == 0;
            for (int c = 0; c < NCH; c++) begin
                start_set_i[c] = ($urandom % 16) == 0;
                start_clr_i[c] = ($urandom % 32) == 0;
            end
            step();
        end
        start_set_i = '0; start_clr_i = '0;
        step();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule